// File: doc/BRIEF.md
# Barrel Shifter with Carry

This block is the operand shifter of a processor data path. One operand goes in each cycle, together with a shift request. One cycle later the block returns the shifted value and the carry bit that the shift defines. It can shift left logically, shift right logically or arithmetically, rotate right, and rotate right by one place through the carry.

The shift request comes from one of four sources, chosen per cycle:
- an explicit 2-bit type with a register-supplied amount;
- the immediate shift field of a wide (32-bit) instruction;
- the immediate shift field of a compact (16+16-bit) instruction;
- an explicit rotate-through-carry request.

The two immediate decoders give an encoded amount of zero its special meanings. For the right shifts a zero amount means a full-width shift. For the rotate type a zero amount means rotate-through-carry by one place.

All outputs are registered and are cleared by a synchronous active-high reset. `WIDTH` sets the operand width. `AMT_W` sets the width of the amount, and it must be at least 5 and able to hold `WIDTH`.

Top module: `bs_shift_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `out_result`, `out_carry` and `out_error` become 0 at that edge.
- R2: The outputs for a request sampled at rising edge k appear after edge k. `out_valid` after edge k equals `in_valid` at edge k.
- R3: `src_sel` selects the request source: 0 is register, 1 is wide immediate, 2 is compact immediate, 3 is explicit rotate-through-carry. In register mode, `shift_type` 0, 1, 2 and 3 select logical left, logical right, arithmetic right and rotate right. When the register-mode amount is 0, the result equals the operand and the carry equals `carry_in`.
- R4: Logical left by n ≥ 1 shifts zeros in from the bottom. The carry is operand bit WIDTH−n for n ≤ WIDTH, and 0 for larger n, which also gives a result of 0.
- R5: Logical right by n ≥ 1 shifts zeros in from the top. The carry is operand bit n−1 for n ≤ WIDTH. A shift above WIDTH gives result 0 and carry 0.
- R6: Arithmetic right by n ≥ 1 fills from the top with the sign bit. The carry is operand bit n−1. For n ≥ WIDTH the result is all sign bits and the carry equals the sign bit.
- R7: Rotate right by n ≥ 1 rotates by n modulo WIDTH. The carry is the top bit of the rotated result.
- R8: Rotate-through-carry (source 3 with amount 1) returns `carry_in` in the top bit and operand bits WIDTH−1..1 below it. The carry is operand bit 0.
- R9: Source 3 with an amount other than 1 is invalid. It sets `out_error`, and `out_result` and `out_carry` are 0.
- R10: The wide immediate layout takes the type from `imm_field[6:5]` and the 5-bit amount from `imm_field[11:7]`. Amount 0 means WIDTH for types 1 and 2, and rotate-through-carry by one for type 3. `shift_type`, `shift_amt` and the other field bits are ignored.
- R11: The compact layout takes the type from `imm_field[5:4]` and the amount from `{imm_field[14:12], imm_field[7:6]}`. It follows the same zero-amount rules as R10 and ignores the other inputs in the same way.
- R12: `out_error` is never set for sources 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| src_sel | input | 2 | Request source (0 register, 1 wide immediate, 2 compact immediate, 3 rotate-through-carry) |
| shift_type | input | 2 | Shift type for register mode |
| shift_amt | input | AMT_W | Amount for register mode and source 3 |
| imm_field | input | 16 | Instruction bits holding an immediate shift field |
| operand | input | WIDTH | Value to shift |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Registered request-present flag |
| out_result | output | WIDTH | Registered shifted value |
| out_carry | output | 1 | Registered carry-out |
| out_error | output | 1 | Registered invalid-request flag |

## Verification
The bench builds the unit with `WIDTH` = 8 and `AMT_W` = 5. Every register-mode combination of operand, type, amount 0..31 and carry-in is then small enough to sweep completely. That sweep includes amounts at, below and well beyond the width, where carries fall off the ends or saturate to the sign. Rotate-through-carry is swept over all operands and all amounts, so both the valid request and every invalid one are covered. Both immediate layouts are swept over every type and 5-bit amount, with junk in the unused field bits and the register inputs, across a spread of operands.

// File: rtl/bs_pkg.sv
package bs_pkg;

  typedef enum logic [2:0] {
    K_LSL = 3'd0,
    K_LSR = 3'd1,
    K_ASR = 3'd2,
    K_ROR = 3'd3,
    K_RRX = 3'd4
  } shift_kind_e;

  typedef enum logic [1:0] {
    SRC_REG     = 2'd0,
    SRC_WIDE    = 2'd1,
    SRC_COMPACT = 2'd2,
    SRC_EXT     = 2'd3
  } src_e;

  localparam int IMM_FIELD_W = 16;
  localparam int IMM_AMT_W   = 5;

  function automatic shift_kind_e type_to_kind(input logic [1:0] t);
    case (t)
      2'd0:    return K_LSL;
      2'd1:    return K_LSR;
      2'd2:    return K_ASR;
      default: return K_ROR;
    endcase
  endfunction

endpackage

// File: rtl/bs_imm_decode.sv
module bs_imm_decode
  import bs_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int AMT_W   = 8,
  parameter bit COMPACT = 1'b0
) (
  input  logic [IMM_FIELD_W-1:0] field,
  output shift_kind_e            kind,
  output logic [AMT_W-1:0]       amt
);

  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(WIDTH);

  logic [1:0]           raw_type;
  logic [IMM_AMT_W-1:0] raw_amt;

  generate
    if (COMPACT) begin : g_compact
      assign raw_type = field[5:4];
      assign raw_amt  = {field[14:12], field[7:6]};
    end else begin : g_wide
      assign raw_type = field[6:5];
      assign raw_amt  = field[11:7];
    end
  endgenerate

  always_comb begin
    kind = type_to_kind(raw_type);
    amt  = AMT_W'(raw_amt);
    if (raw_amt == '0) begin
      case (raw_type)
        2'd1, 2'd2: amt = FULL_AMT;
        2'd3: begin
          kind = K_RRX;
          amt  = AMT_W'(1);
        end
        default: amt = '0;
      endcase
    end
  end

endmodule

// File: rtl/bs_shift_core.sv
module bs_shift_core
  import bs_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  shift_kind_e       kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic [WIDTH-1:0]  operand,
  input  logic              carry_in,
  output logic [WIDTH-1:0]  result,
  output logic              carry_out,
  output logic              error
);

  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(WIDTH);

  logic [WIDTH:0]        lsl_ext;
  logic [WIDTH:0]        lsr_ext;
  logic signed [WIDTH:0] asr_ext;
  logic [AMT_W-1:0]      rot;
  logic [WIDTH-1:0]      ror_val;

  always_comb begin
    lsl_ext = {1'b0, operand} << amt;
    lsr_ext = {operand, 1'b0} >> amt;
    asr_ext = $signed({operand, 1'b0}) >>> amt;
    rot     = amt % W_AMT;
    ror_val = (operand >> rot) | (operand << (W_AMT - rot));
  end

  always_comb begin
    result    = operand;
    carry_out = carry_in;
    error     = 1'b0;
    if (kind == K_RRX) begin
      if (amt == AMT_W'(1)) begin
        result    = {carry_in, operand[WIDTH-1:1]};
        carry_out = operand[0];
      end else begin
        result    = '0;
        carry_out = 1'b0;
        error     = 1'b1;
      end
    end else if (amt != '0) begin
      case (kind)
        K_LSL: {carry_out, result} = lsl_ext;
        K_LSR: {result, carry_out} = lsr_ext;
        K_ASR: {result, carry_out} = asr_ext;
        default: begin
          result    = ror_val;
          carry_out = ror_val[WIDTH-1];
        end
      endcase
    end
  end

endmodule

// File: rtl/bs_shift_unit.sv
module bs_shift_unit
  import bs_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [1:0]             src_sel,
  input  logic [1:0]             shift_type,
  input  logic [AMT_W-1:0]       shift_amt,
  input  logic [IMM_FIELD_W-1:0] imm_field,
  input  logic [WIDTH-1:0]       operand,
  input  logic                   carry_in,
  output logic                   out_valid,
  output logic [WIDTH-1:0]       out_result,
  output logic                   out_carry,
  output logic                   out_error
);

  localparam int N_LAYOUT = 2;

  shift_kind_e      dec_kind [N_LAYOUT];
  logic [AMT_W-1:0] dec_amt  [N_LAYOUT];

  generate
    for (genvar g = 0; g < N_LAYOUT; g++) begin : g_dec
      bs_imm_decode #(
        .WIDTH  (WIDTH),
        .AMT_W  (AMT_W),
        .COMPACT(g == 1)
      ) u_dec (
        .field(imm_field),
        .kind (dec_kind[g]),
        .amt  (dec_amt[g])
      );
    end
  endgenerate

  shift_kind_e      sel_kind;
  logic [AMT_W-1:0] sel_amt;

  always_comb begin
    case (src_e'(src_sel))
      SRC_WIDE: begin
        sel_kind = dec_kind[0];
        sel_amt  = dec_amt[0];
      end
      SRC_COMPACT: begin
        sel_kind = dec_kind[1];
        sel_amt  = dec_amt[1];
      end
      SRC_EXT: begin
        sel_kind = K_RRX;
        sel_amt  = shift_amt;
      end
      default: begin
        sel_kind = type_to_kind(shift_type);
        sel_amt  = shift_amt;
      end
    endcase
  end

  logic [WIDTH-1:0] core_result;
  logic             core_carry;
  logic             core_error;

  bs_shift_core #(
    .WIDTH(WIDTH),
    .AMT_W(AMT_W)
  ) u_core (
    .kind     (sel_kind),
    .amt      (sel_amt),
    .operand  (operand),
    .carry_in (carry_in),
    .result   (core_result),
    .carry_out(core_carry),
    .error    (core_error)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_carry  <= 1'b0;
      out_error  <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      out_result <= core_result;
      out_carry  <= core_carry;
      out_error  <= core_error;
    end
  end

endmodule

// File: rtl/bs_shift_unit_chk.sv
module bs_shift_unit_chk #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       src_sel,
  input logic [AMT_W-1:0] shift_amt,
  input logic [WIDTH-1:0] operand,
  input logic             carry_in,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_result,
  input logic             out_carry,
  input logic             out_error
);

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_zero_amt_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_sel == 2'd0 && shift_amt == '0) |=>
      (out_result == $past(operand) && out_carry == $past(carry_in)));

  p_rrx_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_sel == 2'd3 && shift_amt == AMT_W'(1)) |=>
      (out_result == {$past(carry_in), $past(operand[WIDTH-1:1])} &&
       out_carry == $past(operand[0])));

  p_error_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_error) |-> (out_result == '0 && !out_carry));

  p_no_error_r12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_sel != 2'd3) |=> !out_error);

endmodule

bind bs_shift_unit bs_shift_unit_chk #(
  .WIDTH(WIDTH),
  .AMT_W(AMT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .src_sel   (src_sel),
  .shift_amt (shift_amt),
  .operand   (operand),
  .carry_in  (carry_in),
  .out_valid (out_valid),
  .out_result(out_result),
  .out_carry (out_carry),
  .out_error (out_error)
);

// File: tb/bs_shift_unit_bench.sv
`timescale 1ns/1ps
module bs_shift_unit_bench;

  localparam int BW = 8;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [1:0]    src_sel;
  logic [1:0]    shift_type;
  logic [AW-1:0] shift_amt;
  logic [15:0]   imm_field;
  logic [BW-1:0] operand;
  logic          carry_in;
  logic          out_valid;
  logic [BW-1:0] out_result;
  logic          out_carry;
  logic          out_error;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bs_shift_unit #(.WIDTH(BW), .AMT_W(AW)) u_bs_shift_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_sel(src_sel),
    .shift_type(shift_type), .shift_amt(shift_amt), .imm_field(imm_field),
    .operand(operand), .carry_in(carry_in), .out_valid(out_valid),
    .out_result(out_result), .out_carry(out_carry), .out_error(out_error)
  );

  // kind: 0 lsl, 1 lsr, 2 asr, 3 ror, 4 rotate-through-carry; returns {err, carry, result}
  function automatic logic [BW+1:0] model(input int kind, input int amt,
                                          input logic [BW-1:0] op, input logic cin);
    logic [BW-1:0] v = op;
    logic          c = cin;
    if (kind == 4) begin
      if (amt != 1) return {1'b1, 1'b0, {BW{1'b0}}};
      return {1'b0, op[0], cin, op[BW-1:1]};
    end
    for (int i = 0; i < amt; i++) begin
      case (kind)
        0: begin c = v[BW-1]; v = v << 1; end
        1: begin c = v[0]; v = v >> 1; end
        2: begin c = v[0]; v = {v[BW-1], v[BW-1:1]}; end
        default: begin v = {v[0], v[BW-1:1]}; c = v[BW-1]; end
      endcase
    end
    return {1'b0, c, v};
  endfunction

  function automatic void decode(input logic [1:0] t, input int a,
                                 output int kind, output int amt);
    kind = t;
    amt  = a;
    if (a == 0 && (t == 2'd1 || t == 2'd2)) amt = BW;
    if (a == 0 && t == 2'd3) begin kind = 4; amt = 1; end
  endfunction

  task automatic apply(input logic [1:0] src, input logic [1:0] t, input int a,
                       input logic [BW-1:0] op, input logic cin);
    int            kind, amt;
    logic [BW+1:0] exp, act;
    logic [15:0]   junk;
    string         tag;
    junk = 16'(op * 16'h9E37 + a * 16'h1357);
    imm_field  = junk;
    shift_type = t;
    shift_amt  = AW'(a);
    case (src)
      2'd1: begin
        imm_field[6:5] = t; imm_field[11:7] = 5'(a);
        shift_type = junk[1:0]; shift_amt = junk[AW+1:2];
        decode(t, a, kind, amt); tag = "R10";
      end
      2'd2: begin
        imm_field[5:4] = t; imm_field[7:6] = 2'(a); imm_field[14:12] = 3'(a >> 2);
        shift_type = junk[1:0]; shift_amt = junk[AW+1:2];
        decode(t, a, kind, amt); tag = "R11";
      end
      2'd3: begin
        kind = 4; amt = a; tag = (a == 1) ? "R8" : "R9";
      end
      default: begin
        kind = t; amt = a;
        if (a == 0) tag = "R3";
        else case (t)
          2'd0: tag = "R4";
          2'd1: tag = "R5";
          2'd2: tag = "R6";
          default: tag = "R7";
        endcase
      end
    endcase
    exp = model(kind, amt, op, cin);
    src_sel  = src;
    operand  = op;
    carry_in = cin;
    in_valid = 1'b1;
    @(negedge clk);
    act = {out_error, out_carry, out_result};
    checks++;
    if (act !== exp || out_valid !== 1'b1) begin
      errors++;
      $display("FAIL %s src=%0d t=%0d a=%0d op=%h cin=%0d: actual err/c/res=%b valid=%b expected %b",
               tag, src, t, a, op, cin, act, out_valid, exp);
    end
    if (src != 2'd3) begin
      checks++;
      if (out_error !== 1'b0) begin
        errors++;
        $display("FAIL R12 src=%0d: actual error=%b expected 0", src, out_error);
      end
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; src_sel = 2'd0; shift_type = 2'd0;
    shift_amt = '1; imm_field = 16'hFFFF; operand = '1; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    // R1: cleared under reset even with active inputs
    checks++;
    if ({out_valid, out_result, out_carry, out_error} !== '0) begin
      errors++;
      $display("FAIL R1: actual %b expected 0", {out_valid, out_result, out_carry, out_error});
    end
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    // R2: idle input gives idle output one cycle later
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2: actual out_valid=%b expected 0", out_valid);
    end
    // R2: valid returns after a single idle cycle
    apply(2'd0, 2'd0, 1, 8'h81, 1'b0);
    in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2: actual out_valid=%b expected 0 after idle", out_valid);
    end

    // Register mode: R3..R7 exhaustive
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 32; a++)
        for (int op = 0; op < 256; op++)
          for (int c = 0; c < 2; c++)
            apply(2'd0, 2'(t), a, 8'(op), 1'(c));

    // Rotate-through-carry: R8 valid, R9 invalid amounts
    for (int a = 0; a < 32; a++)
      for (int op = 0; op < 256; op++)
        for (int c = 0; c < 2; c++)
          apply(2'd3, 2'd0, a, 8'(op), 1'(c));

    // Immediate layouts: R10 wide, R11 compact
    for (int s = 1; s < 3; s++)
      for (int t = 0; t < 4; t++)
        for (int a = 0; a < 32; a++)
          for (int op = 0; op < 256; op += 3)
            apply(2'(s), 2'(t), a, 8'(op), 1'(op[1] ^ a[0]));

    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule